// File: doc/BRIEF.md
# Bit-parallel Shift-Or string matcher

This block scans a byte stream for one fixed pattern of exactly `PAT_W` symbols and flags every stream position where a copy of that pattern ends, overlapping copies included. It does not compare a window of characters. Instead it keeps a `PAT_W`-bit state vector with one bit per pattern position. For each accepted symbol it shifts the vector up by one place and ORs in a precomputed mask word chosen by that symbol. A zero that survives all the way to the top bit means the last `PAT_W` symbols equal the pattern.

Software or a loader fills the mask table through a small write port before streaming starts. Each table address is a symbol value. In a mask word, bit i is 0 exactly when pattern position i holds that symbol, and bit 0 is the first pattern character. The matcher then accepts one symbol per cycle while `in_valid` is high. A `restart` pulse begins a fresh search, for example at a packet boundary, and keeps the loaded table.

Top module: `shiftor_matcher`

## Requirements
- R1: After `rst` (synchronous, active high), `out_valid` and `match_o` are 0, the state vector is all ones, and every table entry reads as all ones, so no stream can match until masks are written.
- R2: A write with `tbl_we` high stores `tbl_wdata` at symbol `tbl_addr`. For every later symbol equal to `tbl_addr`, that word is the mask. The mask has bit i = 0 exactly where pattern position i equals the symbol, and bit 0 is the first pattern character.
- R3: Each accepted symbol updates the state to (state shifted left by one, with 0 entering bit 0) OR mask, and a match is reported when bit `PAT_W`-1 of the updated state is 0. With masks for `ababc`, the text `abdababababc` matches once, at its last symbol.
- R4: A symbol whose entry was never written since reset uses an all-ones mask, so any pattern occurrence that contains it is not reported.
- R5: Outputs are registered. `out_valid` is high in the cycle after a symbol is accepted, and `match_o` is high in that same cycle only if that symbol completed the pattern. With no accepted symbol, both are 0.
- R6: A cycle with `in_valid` low leaves the state unchanged, so idle gaps inside a pattern occurrence do not break it.
- R7: `restart` sets the state to all ones and keeps the table. It takes priority over `in_valid`: the symbol presented with it is dropped and the next cycle shows `out_valid` = 0.
- R8: Overlapping occurrences are each reported. With pattern `aaaaa`, a run of n ≥ 5 `a` symbols after a restart gives matches on symbols 5 through n.
- R9: Table writes must not coincide with `in_valid` high. A write cycle with `in_valid` low produces no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Mask table write enable |
| tbl_addr | input | SYM_W | Symbol whose mask is written |
| tbl_wdata | input | PAT_W | Mask word to store |
| restart | input | 1 | Return the state to all ones; table kept |
| in_valid | input | 1 | `in_sym` carries a stream symbol this cycle |
| in_sym | input | SYM_W | Stream symbol |
| out_valid | output | 1 | A symbol was accepted in the previous cycle |
| match_o | output | 1 | That symbol ended an occurrence of the pattern |

## Verification
The bench sweeps every six-symbol string over a four-letter alphabet as one continuous stream. A window-comparing reference model checks each cycle, so a wrong shift direction, a wrong bit order in the masks, or a match taken from the wrong state bit shows up as missed or spurious pulses. Separate cases cover these failure modes:
- a design that forgets to clear the table on reset, or lets unwritten symbols read as zero, matches on an empty table or across a foreign byte;
- one that shifts during idle cycles breaks occurrences that have gaps in them;
- one that lets a symbol through alongside `restart`, or clears the table on restart, reports false or missing matches;
- one that blocks overlapping occurrences misses the repeated pulses of an `aaaaa` run.

// File: rtl/shiftor_pkg.sv
package shiftor_pkg;

  // What the state register does in a given cycle.
  typedef enum logic [1:0] {
    STEP_HOLD    = 2'd0,
    STEP_RESTART = 2'd1,
    STEP_ADVANCE = 2'd2
  } step_e;

  function automatic step_e decode_step(input logic restart, input logic in_valid);
    if (restart)       return STEP_RESTART;
    else if (in_valid) return STEP_ADVANCE;
    else               return STEP_HOLD;
  endfunction

endpackage

// File: rtl/shiftor_mask_table.sv
// Per-symbol mask memory. Storage has no reset so it maps to distributed
// RAM; a separate written-flag vector makes untouched entries read all ones.
module shiftor_mask_table #(
  parameter int PAT_W = 8,
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_addr,
  input  logic [PAT_W-1:0] wr_data,
  input  logic [SYM_W-1:0] rd_addr,
  output logic [PAT_W-1:0] rd_mask
);
  localparam int DEPTH = 1 << SYM_W;

  logic [PAT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        written_q <= '0;
    else if (wr_en) written_q[wr_addr] <= 1'b1;
  end

  always_comb begin
    if (written_q[rd_addr]) rd_mask = mem[rd_addr];
    else                    rd_mask = '1;
  end
endmodule

// File: rtl/shiftor_state_engine.sv
// Shift-Or state register and its next-state logic.
module shiftor_state_engine
  import shiftor_pkg::*;
#(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            step,
  input  logic [PAT_W-1:0] mask,
  output logic [PAT_W-1:0] state_q,
  output logic             hit_next
);
  localparam int MSB = PAT_W - 1;

  logic [PAT_W-1:0] advanced;

  assign advanced = {state_q[MSB-1:0], 1'b0} | mask;
  assign hit_next = ~advanced[MSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '1;
    end else begin
      case (step)
        STEP_RESTART: state_q <= '1;
        STEP_ADVANCE: state_q <= advanced;
        default:      state_q <= state_q;
      endcase
    end
  end
endmodule

// File: rtl/shiftor_match_reg.sv
// Registered valid/match outputs.
module shiftor_match_reg
  import shiftor_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_e step,
  input  logic  hit_next,
  output logic  out_valid,
  output logic  match_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      match_o   <= 1'b0;
    end else begin
      out_valid <= (step == STEP_ADVANCE);
      match_o   <= (step == STEP_ADVANCE) && hit_next;
    end
  end
endmodule

// File: rtl/shiftor_matcher.sv
module shiftor_matcher
  import shiftor_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [SYM_W-1:0] tbl_addr,
  input  logic [PAT_W-1:0] tbl_wdata,
  input  logic             restart,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_sym,
  output logic             out_valid,
  output logic             match_o
);
  step_e            step;
  logic [PAT_W-1:0] sym_mask;
  logic [PAT_W-1:0] state_q;
  logic             hit_next;

  assign step = decode_step(restart, in_valid);

  shiftor_mask_table #(.PAT_W(PAT_W), .SYM_W(SYM_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_addr (in_sym),
    .rd_mask (sym_mask)
  );

  shiftor_state_engine #(.PAT_W(PAT_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .mask     (sym_mask),
    .state_q  (state_q),
    .hit_next (hit_next)
  );

  shiftor_match_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .hit_next  (hit_next),
    .out_valid (out_valid),
    .match_o   (match_o)
  );
endmodule

// File: rtl/shiftor_matcher_chk.sv
module shiftor_matcher_chk #(
  parameter int PAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tbl_we,
  input logic             restart,
  input logic             in_valid,
  input logic             out_valid,
  input logic             match_o,
  input logic [PAT_W-1:0] state_q
);
  a_r9_no_write_while_streaming: assert property (@(posedge clk) disable iff (rst)
    !(tbl_we && in_valid));

  a_r5_match_needs_symbol: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(in_valid) && !$past(restart));

  a_r7_restart_ones: assert property (@(posedge clk) disable iff (rst)
    restart |=> (state_q == {PAT_W{1'b1}}) && !out_valid && !match_o);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!restart && !in_valid) |=> $stable(state_q) && !out_valid);

  a_r3_match_tracks_msb: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (match_o == !state_q[PAT_W-1]));

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (state_q == {PAT_W{1'b1}}) && !match_o && !out_valid);
endmodule

bind shiftor_matcher shiftor_matcher_chk #(.PAT_W(PAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tbl_we    (tbl_we),
  .restart   (restart),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .match_o   (match_o),
  .state_q   (state_q)
);

// File: tb/test_shiftor_matcher.sv
module test_shiftor_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int PAT_W = 5;
  localparam int SYM_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tbl_we = 1'b0;
  logic [SYM_W-1:0] tbl_addr = '0;
  logic [PAT_W-1:0] tbl_wdata = '0;
  logic             restart = 1'b0;
  logic             in_valid = 1'b0;
  logic [SYM_W-1:0] in_sym = '0;
  logic             out_valid;
  logic             match_o;

  int checks = 0;
  int failures = 0;

  // reference model: window comparison, independent of the bit-parallel method
  logic [7:0] pat [PAT_W];
  logic [7:0] hist [PAT_W];
  int         seen = 0;
  logic       loaded = 1'b0;
  int         match_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shiftor_matcher #(.PAT_W(PAT_W), .SYM_W(SYM_W)) i_shiftor_matcher (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .restart(restart), .in_valid(in_valid),
    .in_sym(in_sym), .out_valid(out_valid), .match_o(match_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tbl_we = 1'b0; in_valid = 1'b0; restart = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R1 out_valid after reset", out_valid, 1'b0);
    check("R1 match after reset", match_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    seen = 0;
    loaded = 1'b0;
  endtask

  // Writes one mask per pattern position; in_valid stays low (R9).
  task automatic load_pattern(input string s);
    for (int i = 0; i < PAT_W; i++) pat[i] = s[i];
    for (int i = 0; i < PAT_W; i++) begin
      logic [PAT_W-1:0] m;
      m = '1;
      for (int j = 0; j < PAT_W; j++) if (pat[j] == pat[i]) m[j] = 1'b0;
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = pat[i]; tbl_wdata = m; in_valid = 1'b0;
      @(posedge clk); #1;
      check("R9 write cycle output idle", out_valid | match_o, 1'b0);
    end
    @(negedge clk);
    tbl_we = 1'b0;
    loaded = 1'b1;
  endtask

  task automatic step(input logic v, input logic [7:0] s, input logic rs, input string req);
    logic exp_v, exp_m;
    @(negedge clk);
    in_valid = v; in_sym = s; restart = rs;
    @(posedge clk); #1;
    if (rs) begin
      seen = 0; exp_v = 1'b0; exp_m = 1'b0;
    end else if (v) begin
      for (int i = 0; i < PAT_W-1; i++) hist[i] = hist[i+1];
      hist[PAT_W-1] = s;
      seen++;
      exp_v = 1'b1;
      exp_m = loaded && (seen >= PAT_W);
      for (int i = 0; i < PAT_W; i++) if (hist[i] != pat[i]) exp_m = 1'b0;
    end else begin
      exp_v = 1'b0; exp_m = 1'b0;
    end
    check({req, " valid"}, out_valid, exp_v);
    check({req, " match"}, match_o, exp_m);
    if (match_o) match_count++;
    @(negedge clk);
    in_valid = 1'b0; restart = 1'b0;
  endtask

  task automatic feed(input string s, input string req);
    for (int i = 0; i < s.len(); i++) step(1'b1, s[i], 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAT_W; i++) begin pat[i] = 8'h00; hist[i] = 8'h00; end
    do_reset();

    // R1: empty table never matches
    feed("ababcababc", "R1 empty table");

    // R3: worked example, exactly one match at the final symbol
    load_pattern("ababc");
    step(1'b0, 8'h00, 1'b1, "R7 restart");
    match_count = 0;
    feed("abdababababc", "R3 example");
    checks++;
    if (match_count != 1) begin
      failures++;
      $display("FAIL R3 match count: actual=%0d expected=1", match_count);
    end

    // R5: output is 0 while the completing symbol is presented, 1 the cycle after
    step(1'b1, "x", 1'b1, "R7 restart drops symbol");
    feed("abab", "R5 prefix");
    @(negedge clk);
    in_valid = 1'b1; in_sym = "c"; #1;
    check("R5 no combinational match", match_o, 1'b0);
    @(posedge clk); #1;
    check("R5 match one cycle later", match_o, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R5 match drops when idle", match_o, 1'b0);
    check("R5 valid drops when idle", out_valid, 1'b0);
    for (int i = 0; i < PAT_W-1; i++) hist[i] = hist[i+1];
    hist[PAT_W-1] = "c"; seen++;

    // R2: near-exhaustive sweep of all 6-symbol strings over a..d, one stream
    step(1'b0, 8'h00, 1'b1, "R7 restart");
    for (int n = 0; n < 4096; n++)
      for (int d = 0; d < 6; d++)
        step(1'b1, 8'h61 + 8'((n >> (2*d)) & 3), 1'b0, "R2 sweep");

    // R6: idle gaps inside an occurrence
    step(1'b0, 8'h00, 1'b1, "R7 restart");
    step(1'b1, "a", 1'b0, "R6 gap"); step(1'b0, "z", 1'b0, "R6 gap");
    step(1'b1, "b", 1'b0, "R6 gap"); step(1'b0, "c", 1'b0, "R6 gap");
    step(1'b1, "a", 1'b0, "R6 gap"); step(1'b1, "b", 1'b0, "R6 gap");
    step(1'b0, "a", 1'b0, "R6 gap"); step(1'b1, "c", 1'b0, "R6 gap end");

    // R7: restart mid-pattern, with a symbol alongside, then table still usable
    feed("aba", "R7 prefix");
    step(1'b1, "b", 1'b1, "R7 restart with symbol");
    feed("c", "R7 no match after restart");
    feed("ababc", "R7 table kept");

    // R4: unwritten symbols read all ones
    step(1'b0, 8'h00, 1'b1, "R7 restart");
    feed("ab", "R4 prefix");
    step(1'b1, 8'hFF, 1'b0, "R4 foreign byte");
    feed("abc", "R4 after foreign");
    step(1'b1, 8'h00, 1'b0, "R4 zero byte");
    feed("ababc", "R4 recovers");

    // R8: overlapping occurrences
    do_reset();
    load_pattern("aaaaa");
    step(1'b0, 8'h00, 1'b1, "R7 restart");
    match_count = 0;
    feed("aaaaaaaa", "R8 overlap");
    checks++;
    if (match_count != 4) begin
      failures++;
      $display("FAIL R8 overlap count: actual=%0d expected=4", match_count);
    end

    // R2: another pattern after reset, only new masks in effect
    do_reset();
    load_pattern("dcbad");
    feed("dcbadcbadaaaaadcbad", "R2 second pattern");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule